// File: doc/BRIEF.md
# Prescaled Overflow Timer with Interrupt Request

This block is an 8-bit timer that counts upward and raises an interrupt when it wraps. A CPU-clock enable feeds a prescaler. Software picks the prescaler divide ratio from a mode register, so the timer advances once every 2 to 256 CPU clocks. When the counter passes from FFh to 00h, a sticky request flag is set. If the timer interrupt enable and the global interrupt enable were both 1 at that moment, a one-cycle vector request pulse is also issued to the CPU.

The request flag does not depend on the enable. Turning the enable on after a pending overflow does not deliver that overflow; only the next overflow can. Software clears the flag by writing 0 to it. Software also reloads the start value, because the counter is never reloaded automatically.

Software reaches the block through one write port with a 2-bit address. Address 0 is the mode register, address 1 is the counter and address 2 is the control register. The counter value and the request flag can be read on dedicated outputs.

Top module: `ovf_timer`

## Requirements
- R1: The counter is 8 bits wide. It increases by one on every prescaled tick. Each tick that moves it from FFh to 00h is an overflow event.
- R2: Bits [6:4] of the mode register (address 0) hold the prescaler code n. The timer ticks once every 256>>n cycles in which `cpu_tick` is 1: code 0 divides by 256, code 2 (mode value 20h) by 64, and code 7 by 2. Cycles with `cpu_tick` at 0 do not advance the prescaler.
- R3: Mode bit 7 is the timer run bit. While it is 0, the counter holds its value and the prescaler stays cleared. Every write to the mode register restarts the prescaler from zero.
- R4: Every overflow sets the request flag to 1, whatever the value of the timer interrupt enable.
- R5: The vector request pulse `vec_req` lasts exactly one cycle. It rises on the same clock edge on which an overflow sets the flag. It is issued only if control bit 0 (timer interrupt enable) and control bit 2 (global enable) were both 1 before that edge.
- R6: If the flag was set while the timer interrupt enable was 0, a later write that sets the enable produces no pulse. Only a later overflow can produce one.
- R7: The flag is cleared only by a control-register write (address 2) whose bit 1 is 0. Writing 1 to bit 1 has no effect. An overflow in the same cycle as a clear leaves the flag set.
- R8: Software can write the counter (address 1) at any time, and overflow never reloads it. If a counter write and an overflow fall in the same cycle, the written value is loaded and the flag is still set.
- R9: After reset, the counter, the mode register, the flag, both enables and `vec_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_tick | input | 1 | CPU-clock enable that drives the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 counter, 2 control |
| wr_data | input | 8 | Write data |
| count | output | 8 | Current counter value |
| req_flag | output | 1 | Sticky overflow request flag |
| vec_req | output | 1 | One-cycle interrupt-vector request |

## Verification
A wrong prescaler count or a lost tick appears at `count` within one divide period. It is checked against a behavioural model on every clock, and the 74h-to-overflow interval at /64 is measured as exactly 8960 cycles. A stale or wrongly gated enable state appears as a `vec_req` pulse where none is due, or a missing one, on the very edge of the overflow. The bench therefore counts pulses around the late-enable case and the both-enabled case. Collisions of a write with an overflow are placed on an exact cycle by gating `cpu_tick`, so a wrong priority shows on `count` or `req_flag` one cycle later.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
    localparam int ADDR_MODE = 0;
    localparam int ADDR_CNT  = 1;
    localparam int ADDR_CTL  = 2;

    localparam int CTL_IEN  = 0;
    localparam int CTL_FLAG = 1;
    localparam int CTL_GIE  = 2;

    typedef struct packed {
        logic ien;
        logic gie;
        logic flag;
        logic vec;
    } irq_state_t;
endpackage

// File: rtl/ovf_timer_prescale.sv
module ovf_timer_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             cpu_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PS_W = 1 << SEL_W;

    logic [PS_W-1:0] ps_d, ps_q;
    logic [PS_W:0]   div_full, div_m1;
    logic            last;

    always_comb begin
        // divide = 2^(PS_W - sel) = 2 << ~sel
        div_full = {{(PS_W-1){1'b0}}, 2'b10} << (~sel);
        div_m1   = div_full - {{PS_W{1'b0}}, 1'b1};
        last     = ({1'b0, ps_q} == div_m1);
        tick     = run && !restart && cpu_tick && last;
        ps_d     = ps_q;
        if (!run || restart) begin
            ps_d = '0;
        end else if (cpu_tick) begin
            ps_d = last ? '0 : ps_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end
endmodule

// File: rtl/ovf_timer_count.sv
module ovf_timer_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        ovf   = tick && (cnt_q == {CNT_W{1'b1}});
        cnt_d = cnt_q;
        if (wr)        cnt_d = wdata;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ovf_timer_irq.sv
module ovf_timer_irq
    import ovf_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wd_ien,
    input  logic wd_flag,
    input  logic wd_gie,
    input  logic ovf,
    output logic ien,
    output logic gie,
    output logic flag,
    output logic vec
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vec = 1'b0;
        if (ctl_wr) begin
            st_d.ien = wd_ien;
            st_d.gie = wd_gie;
            if (!wd_flag) st_d.flag = 1'b0;
        end
        if (ovf) begin
            st_d.flag = 1'b1;
            st_d.vec  = st_q.ien && st_q.gie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ien  = st_q.ien;
    assign gie  = st_q.gie;
    assign flag = st_q.flag;
    assign vec  = st_q.vec;
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
    import ovf_timer_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              req_flag,
    output logic              vec_req
);
    localparam int RUN_BIT = CNT_W - 1;
    localparam int SEL_HI  = CNT_W - 2;

    logic [CNT_W-1:0] mode_d, mode_q;
    logic             mode_wr, cnt_wr, ctl_wr, ctl_clr;
    logic             run, tick, ovf, ien, gie;
    logic [SEL_W-1:0] sel;

    always_comb begin
        mode_wr = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));
        cnt_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_CNT));
        ctl_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_CTL));
        ctl_clr = ctl_wr && !wr_data[CTL_FLAG];
        mode_d  = mode_wr ? wr_data : mode_q;
        run     = mode_q[RUN_BIT];
        sel     = mode_q[SEL_HI -: SEL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    ovf_timer_prescale #(.SEL_W(SEL_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(mode_wr),
        .cpu_tick(cpu_tick), .sel(sel), .tick(tick)
    );

    ovf_timer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr(cnt_wr),
        .wdata(wr_data), .cnt(count), .ovf(ovf)
    );

    ovf_timer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
        .wd_ien(wr_data[CTL_IEN]), .wd_flag(wr_data[CTL_FLAG]),
        .wd_gie(wr_data[CTL_GIE]), .ovf(ovf),
        .ien(ien), .gie(gie), .flag(req_flag), .vec(vec_req)
    );
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick,
    input logic             ovf,
    input logic             cnt_wr,
    input logic             ctl_clr,
    input logic             ien,
    input logic             gie,
    input logic [CNT_W-1:0] count,
    input logic             req_flag,
    input logic             vec_req
);
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !cnt_wr |=> count == '0);

    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !cnt_wr |=> $stable(count));

    assert_flag_on_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> req_flag);

    assert_flag_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_flag) |-> $past(tick));

    assert_vec_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> !vec_req);

    assert_vec_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> req_flag);

    assert_vec_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(ien && gie));

    assert_vec_new_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(ovf));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_flag && !ctl_clr |=> req_flag);
endmodule

bind ovf_timer ovf_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .ovf(ovf),
    .cnt_wr(cnt_wr), .ctl_clr(ctl_clr), .ien(ien), .gie(gie),
    .count(count), .req_flag(req_flag), .vec_req(vec_req)
);

// File: tb/ovf_timer_test.sv
module ovf_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] count;
    logic       req_flag, vec_req;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int vec_seen = 0;
    bit done     = 0;

    // behavioural reference state
    int m_cnt = 0, m_mode = 0, m_ps = 0;
    bit m_flag = 0, m_ien = 0, m_gie = 0, m_vec = 0;

    always #10 clk = ~clk;

    ovf_timer uut (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
        .req_flag(req_flag), .vec_req(vec_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // reference model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mode = 0; m_ps = 0;
            m_flag = 0; m_ien = 0; m_gie = 0; m_vec = 0;
        end else begin
            bit t, o;
            int div;
            t = 0; o = 0;
            div = 256 >> ((m_mode >> 4) & 7);
            if (((m_mode & 8'h80) == 0) || (wr_en && wr_addr == 0)) m_ps = 0;
            else if (cpu_tick) begin
                if (m_ps == div - 1) begin m_ps = 0; t = 1; end
                else m_ps++;
            end
            if (t) begin
                if (m_cnt == 255) o = 1;
                m_cnt = (m_cnt + 1) % 256;
            end
            if (wr_en && wr_addr == 1) m_cnt = wr_data;
            m_vec = o && m_ien && m_gie;
            if (wr_en && wr_addr == 2) begin
                m_ien = wr_data[0];
                m_gie = wr_data[2];
                if (!wr_data[1]) m_flag = 0;
            end
            if (o) m_flag = 1;
            if (wr_en && wr_addr == 0) m_mode = wr_data;
        end
    end

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(count == m_cnt[7:0], "R1 count vs model", count, m_cnt);
            check(req_flag == m_flag, "R4 flag vs model", req_flag, m_flag);
            check(vec_req == m_vec, "R5 vec vs model", vec_req, m_vec);
            if (vec_req) vec_seen++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int v0, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(count == 0, "R9 count", count, 0);
        check(req_flag == 0, "R9 flag", req_flag, 0);
        check(vec_req == 0, "R9 vec", vec_req, 0);

        // R4: overflow with enable off sets the flag; R8 no reload
        wr(1, 8'hFC);
        v0 = vec_seen;
        wr(0, 8'hF0);
        idle(12);
        check(req_flag == 1, "R4 flag with ien=0", req_flag, 1);
        check(count < 8'h10, "R8 no reload after wrap", count, 2);
        // R3 stop: count holds
        wr(0, 8'h70);
        n = count;
        idle(20);
        check(count == n, "R3 hold while stopped", count, n);
        // R6 late enable, flag bit written 1 (R7 no effect)
        wr(2, 3'b111);
        idle(10);
        check(vec_seen == v0, "R6 no pulse on late enable", vec_seen, v0);
        check(req_flag == 1, "R7 writing 1 keeps flag", req_flag, 1);
        // R7 clear
        wr(2, 3'b101);
        check(req_flag == 0, "R7 clear by writing 0", req_flag, 0);

        // R5 both enables on: exactly one pulse
        v0 = vec_seen;
        wr(1, 8'hFE);
        wr(0, 8'hF0);
        idle(10);
        check(vec_seen == v0 + 1, "R5 one pulse", vec_seen, v0 + 1);
        check(req_flag == 1, "R5 flag set", req_flag, 1);
        // R5 global enable off: no pulse
        wr(0, 8'h70);
        wr(2, 3'b001);
        v0 = vec_seen;
        wr(1, 8'hFE);
        wr(0, 8'hF0);
        idle(10);
        check(vec_seen == v0, "R5 no pulse with gie=0", vec_seen, v0);
        check(req_flag == 1, "R4 flag with gie=0", req_flag, 1);

        // R8 counter write colliding with overflow, R2 cpu_tick gating
        wr(2, 3'b000);
        cpu_tick = 1'b0;
        wr(0, 8'hF0);
        wr(1, 8'hFF);
        idle(5);
        check(count == 8'hFF, "R2 no advance without cpu_tick", count, 255);
        cpu_tick = 1'b1;
        @(negedge clk);
        wr(1, 8'h33);
        cpu_tick = 1'b0;
        check(count == 8'h33, "R8 write wins over overflow", count, 8'h33);
        check(req_flag == 1, "R8 flag set on collision", req_flag, 1);
        // R7 clear colliding with overflow
        wr(1, 8'hFF);
        cpu_tick = 1'b1;
        @(negedge clk);
        wr(2, 3'b001);
        cpu_tick = 1'b0;
        check(req_flag == 1, "R7 overflow beats clear", req_flag, 1);
        check(count == 0, "R1 wrap to zero", count, 0);
        cpu_tick = 1'b1;

        // R2 interval at 20h with start 74h: 140 ticks x 64
        wr(0, 8'h20);
        wr(1, 8'h74);
        wr(2, 3'b000);
        wr(0, 8'hA0);
        n = 0;
        while (!req_flag) begin @(negedge clk); n++; end
        check(n == 8960, "R2 interval /64 from 74h", n, 8960);
        // R2 code 0 divides by 256
        wr(0, 8'h00);
        wr(1, 8'hFF);
        wr(2, 3'b000);
        wr(0, 8'h80);
        n = 0;
        while (!req_flag) begin @(negedge clk); n++; end
        check(n == 256, "R2 interval /256", n, 256);

        done = 1;
        idle(2);
        finish_run();
    end
endmodule